// File: doc/BRIEF.md
# Floating-Point Sign and Word-Merge Unit

This unit performs the bit-level register operations of a floating-point pipeline on two 64-bit double-precision operands, A and B. It handles plain register copy, clearing, forcing or flipping the sign bit, copying the sign of A onto the magnitude of B, and two 32-bit word merges that combine halves of A and B. No operation looks at the exponent or fraction. NaNs, infinities and denormals pass through as raw bits. No floating-point status or exception flag is read back or changed, apart from sampling a supplied status word for the condition nibble.

A request is taken on a rising clock edge while `req` is high. If the floating-point unit is enabled, the result appears one cycle later with a one-cycle valid pulse. If it is disabled, a one-cycle unavailable strobe is raised instead and the result register keeps its old value. For the sign-type operations, a record bit asks for a 4-bit condition nibble. This nibble is the top four bits of the supplied 32-bit status word, and it is returned alongside the result.

Top module: `fp_sign_merge`

## Requirements
- R1: Operation code 0 (move) and the spare code 7 return B unchanged.
- R2: Operation code 1 (absolute) returns B with bit 63 cleared and bits 62:0 unchanged.
- R3: Operation code 2 (negative absolute) returns B with bit 63 set and bits 62:0 unchanged.
- R4: Operation code 3 (negate) returns B with only bit 63 inverted.
- R5: Operation code 4 (copy-sign) returns bit 63 of A above bits 62:0 of B.
- R6: Operation code 5 (merge-even) returns A[63:32] in the upper half and B[63:32] in the lower half.
- R7: Operation code 6 (merge-odd) returns A[31:0] in the upper half and B[31:0] in the lower half.
- R8: A request sampled with `fpu_en` high drives `res` and a single-cycle `res_vld` pulse on the next cycle. `unavail` stays low.
- R9: A request sampled with `fpu_en` low raises `unavail` for one cycle and leaves `res_vld` low. `res` and `cr1` keep their previous values.
- R10: For operation codes 0 to 4 and 7, an accepted request with `rec` high raises `cr1_vld` for one cycle, and `cr1` becomes `status[31:28]`. With `rec` low, `cr1_vld` stays low and `cr1` is held.
- R11: For the merge codes 5 and 6, `rec` is ignored. `cr1_vld` stays low and `cr1` is held.
- R12: NaN and infinity operands receive no special treatment. The result follows the same bit rules as any other value.
- R13: After reset, `res`, `cr1`, `res_vld`, `cr1_vld` and `unavail` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req | input | 1 | Request, sampled on each rising edge |
| fpu_en | input | 1 | Floating-point unit enabled |
| op | input | 3 | Operation code |
| rec | input | 1 | Record bit: request the condition nibble |
| a | input | 64 | Operand A |
| b | input | 64 | Operand B |
| status | input | 32 | Floating-point status word |
| res | output | 64 | Registered result |
| res_vld | output | 1 | Result valid pulse |
| unavail | output | 1 | Floating-point-unavailable strobe |
| cr1 | output | 4 | Registered condition nibble |
| cr1_vld | output | 1 | Condition nibble valid pulse |

## Verification
The assertions assume that `req`, `fpu_en`, `op`, `rec`, `a`, `b` and `status` carry known values at every rising edge once reset is released. They also assume that any 3-bit code may occur, so code 7 must behave as a move rather than be excluded. The stimulus keeps to this by driving every input to a defined value, changing inputs only on falling edges, and returning `req` low between requests. Random operands are mixed with directed NaN, infinity and sign patterns so that the bitwise rules are checked on exactly the values where an arithmetic path would differ.

// File: rtl/fp_sign_merge.sv
module fp_sign_merge #(
  parameter int DW  = 64,
  parameter int OPW = 3,
  parameter int SW  = 32
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           req,
  input  logic           fpu_en,
  input  logic [OPW-1:0] op,
  input  logic           rec,
  input  logic [DW-1:0]  a,
  input  logic [DW-1:0]  b,
  input  logic [SW-1:0]  status,
  output logic [DW-1:0]  res,
  output logic           res_vld,
  output logic           unavail,
  output logic [3:0]     cr1,
  output logic           cr1_vld
);
  localparam int HW = DW / 2;
  localparam int SB = DW - 1;
  localparam logic [OPW-1:0] OP_ABS   = OPW'(1);
  localparam logic [OPW-1:0] OP_NABS  = OPW'(2);
  localparam logic [OPW-1:0] OP_NEG   = OPW'(3);
  localparam logic [OPW-1:0] OP_CPSGN = OPW'(4);
  localparam logic [OPW-1:0] OP_MEVEN = OPW'(5);
  localparam logic [OPW-1:0] OP_MODD  = OPW'(6);

  logic [DW-1:0] nxt;
  logic          take;
  logic          is_merge;

  assign take     = req & fpu_en;
  assign is_merge = (op == OP_MEVEN) | (op == OP_MODD);

  always_comb begin
    case (op)
      OP_ABS:   nxt = {1'b0, b[SB-1:0]};
      OP_NABS:  nxt = {1'b1, b[SB-1:0]};
      OP_NEG:   nxt = {~b[SB], b[SB-1:0]};
      OP_CPSGN: nxt = {a[SB], b[SB-1:0]};
      OP_MEVEN: nxt = {a[DW-1:HW], b[DW-1:HW]};
      OP_MODD:  nxt = {a[HW-1:0], b[HW-1:0]};
      default:  nxt = b;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res     <= '0;
      res_vld <= 1'b0;
      unavail <= 1'b0;
      cr1     <= '0;
      cr1_vld <= 1'b0;
    end else begin
      res_vld <= take;
      unavail <= req & ~fpu_en;
      cr1_vld <= take & rec & ~is_merge;
      if (take) res <= nxt;
      if (take & rec & ~is_merge) cr1 <= status[SW-1 -: 4];
    end
  end
endmodule

module fp_sign_merge_chk #(
  parameter int DW  = 64,
  parameter int OPW = 3,
  parameter int SW  = 32
) (
  input logic           clk,
  input logic           rst_n,
  input logic           req,
  input logic           fpu_en,
  input logic [OPW-1:0] op,
  input logic           rec,
  input logic [DW-1:0]  a,
  input logic [DW-1:0]  b,
  input logic [SW-1:0]  status,
  input logic [DW-1:0]  res,
  input logic           res_vld,
  input logic           unavail,
  input logic [3:0]     cr1,
  input logic           cr1_vld
);
  a_r8_valid_next: assert property (@(posedge clk) disable iff (!rst_n)
    (req && fpu_en) |=> (res_vld && !unavail));
  a_r8_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    !(req && fpu_en) |=> !res_vld);
  a_r9_unavail: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !fpu_en) |=> (unavail && !res_vld && !cr1_vld));
  a_r9_hold_res: assert property (@(posedge clk) disable iff (!rst_n)
    !(req && fpu_en) |=> $stable(res));
  a_r2_abs: assert property (@(posedge clk) disable iff (!rst_n)
    (req && fpu_en && op == OPW'(1)) |=> (res == {1'b0, $past(b[DW-2:0])}));
  a_r4_neg: assert property (@(posedge clk) disable iff (!rst_n)
    (req && fpu_en && op == OPW'(3)) |=> (res == ($past(b) ^ {1'b1, {(DW-1){1'b0}}})));
  a_r10_cr1: assert property (@(posedge clk) disable iff (!rst_n)
    (req && fpu_en && rec && op != OPW'(5) && op != OPW'(6))
      |=> (cr1_vld && cr1 == $past(status[SW-1 -: 4])));
  a_r11_merge_norec: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OPW'(5) || op == OPW'(6)) |=> (!cr1_vld && $stable(cr1)));
endmodule

bind fp_sign_merge fp_sign_merge_chk #(.DW(DW), .OPW(OPW), .SW(SW)) u_chk (.*);

// File: tb/fp_sign_merge_test.sv
module fp_sign_merge_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, fpu_en = 1'b0, rec = 1'b0;
  logic [2:0]  op = '0;
  logic [63:0] a = '0, b = '0;
  logic [31:0] status = '0;
  logic [63:0] res;
  logic        res_vld, unavail, cr1_vld;
  logic [3:0]  cr1;

  int checks = 0, errors = 0;
  bit finished = 0;
  logic [63:0] res_m = '0;
  logic [3:0]  cr1_m = '0;

  always #2 clk = ~clk;

  fp_sign_merge uut (.clk(clk), .rst_n(rst_n), .req(req), .fpu_en(fpu_en), .op(op),
    .rec(rec), .a(a), .b(b), .status(status), .res(res), .res_vld(res_vld),
    .unavail(unavail), .cr1(cr1), .cr1_vld(cr1_vld));

  function automatic logic [63:0] model(input logic [2:0] o, input logic [63:0] x, input logic [63:0] y);
    case (o)
      3'd1: return {1'b0, y[62:0]};
      3'd2: return {1'b1, y[62:0]};
      3'd3: return {~y[63], y[62:0]};
      3'd4: return {x[63], y[62:0]};
      3'd5: return {x[63:32], y[63:32]};
      3'd6: return {x[31:0], y[31:0]};
      default: return y;
    endcase
  endfunction

  function automatic string rtag(input logic [2:0] o);
    case (o)
      3'd1: return "R2";
      3'd2: return "R3";
      3'd3: return "R4";
      3'd4: return "R5";
      3'd5: return "R6";
      3'd6: return "R7";
      default: return "R1";
    endcase
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic issue(input logic [2:0] o, input logic r, input logic en,
                       input logic [63:0] x, input logic [63:0] y, input logic [31:0] st);
    bit took, rc;
    @(negedge clk);
    req = 1'b1; op = o; rec = r; fpu_en = en; a = x; b = y; status = st;
    took = en;
    rc = en && r && (o != 3'd5) && (o != 3'd6);
    if (took) res_m = model(o, x, y);
    if (rc) cr1_m = st[31:28];
    @(negedge clk);
    req = 1'b0;
    chk(took ? rtag(o) : "R9", res, res_m);
    chk(took ? "R8" : "R9", {63'd0, res_vld}, {63'd0, took});
    chk(took ? "R8" : "R9", {63'd0, unavail}, {63'd0, !took});
    chk((o == 3'd5 || o == 3'd6) ? "R11" : "R10", {63'd0, cr1_vld}, {63'd0, rc});
    chk((o == 3'd5 || o == 3'd6) ? "R11" : "R10", {60'd0, cr1}, {60'd0, cr1_m});
  endtask

  initial begin
    #(4 * 200000);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    #1;
    chk("R13", res, 64'd0);
    chk("R13", {59'd0, res_vld, unavail, cr1_vld, 2'b00}, 64'd0);
    chk("R13", {60'd0, cr1}, 64'd0);
    #10 rst_n = 1'b1;
    issue(3'd0, 1'b1, 1'b1, 64'h1111_2222_3333_4444, 64'hC000_0000_0000_0001, 32'hA000_0000);
    issue(3'd7, 1'b0, 1'b1, 64'h0, 64'h8123_4567_89AB_CDEF, 32'h5000_0000);
    issue(3'd1, 1'b1, 1'b1, 64'h0, 64'hFFF8_0000_0000_0001, 32'h3000_0000); // R12 negative NaN
    issue(3'd2, 1'b0, 1'b1, 64'h0, 64'h7FF0_0000_0000_0000, 32'h0);         // R12 infinity
    issue(3'd3, 1'b1, 1'b1, 64'h0, 64'h7FF8_0000_0000_0000, 32'hF000_0000); // R12 quiet NaN
    issue(3'd4, 1'b0, 1'b1, 64'h8000_0000_0000_0000, 64'h7FFF_FFFF_FFFF_FFFF, 32'h0);
    issue(3'd5, 1'b1, 1'b1, 64'hAAAA_BBBB_CCCC_DDDD, 64'h1111_2222_3333_4444, 32'h6000_0000); // R11
    issue(3'd6, 1'b1, 1'b1, 64'hAAAA_BBBB_CCCC_DDDD, 64'h1111_2222_3333_4444, 32'h9000_0000); // R11
    issue(3'd3, 1'b1, 1'b0, 64'h0, 64'h1234, 32'hE000_0000); // R9
    issue(3'd5, 1'b1, 1'b0, 64'h5, 64'h6, 32'h1000_0000);    // R9
    @(negedge clk);
    chk("R8", {63'd0, res_vld}, 64'd0);
    chk("R9", {63'd0, unavail}, 64'd0);
    for (int i = 0; i < 400; i++) begin
      issue(3'($urandom), 1'($urandom), ($urandom % 8) != 0,
            {$urandom, $urandom}, {$urandom, $urandom}, $urandom);
    end
    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule